// File: doc/BRIEF.md
# Sliding-Window Bitstream Fast Detector

This block watches the raw one-bit stream from a sigma-delta modulator. It runs on the modulator clock and flags an over-current condition within a single clock, well before any decimation filter could produce a sample. It counts the zeros among the most recent bits of the stream, over a window whose length can be set from 4 to 32 bits. It compares that count against an upper and a lower limit. When the count leaves the band between the two limits, the block raises a trip output. A separate sticky flag records which limit was broken, and both flags stay set until an explicit clear.

A small state machine governs the block. It has three states. IDLE is the disabled state, and the window is held empty there. BLANK is a start-up period of 32 modulator clocks in which the window fills and no comparison is made. WATCH is the state in which comparisons are live. The transitions are:
- IDLE to BLANK on the first clock with the enable high.
- BLANK to WATCH on the 32nd clock that shifts a bit into the window.
- BLANK or WATCH back to BLANK, with the window emptied, when the effective window length changes.
- Any state to IDLE when the enable is low.

Top module: `fd_fast_detect`

## Requirements
- R1: The window length input is an unsigned 6-bit number of bits. Values below 4 act as 4 and values above 32 act as 32. A change of the input that leaves the effective length unchanged does not restart the block.
- R2: In WATCH, the zero count used for comparison equals the number of 0 bits among the last L sampled stream bits, where L is the effective length. Only bits sampled since the last restart are counted.
- R3: After the enabling clock edge, no new error is raised until 32 further clock edges have shifted stream bits into the window. From the cycle after that 32nd edge, comparisons are live.
- R4: In WATCH, a zero count strictly greater than the upper limit drives `err_hi_o` and `trip_o` high in the same cycle in which the count shows the crossing.
- R5: In WATCH, a zero count strictly less than the lower limit drives `err_lo_o` and `trip_o` high in the same cycle in which the count shows the crossing.
- R6: Each error flag is sticky and clears only on a clock edge with `clr_i` high. A violation present at that edge keeps the flag set. `trip_o` is high exactly when either flag is high. After reset, all three outputs are low.
- R7: A clock edge with `en_i` low empties the window and returns to IDLE. After re-enabling, a full BLANK period applies again. Sticky flags are kept.
- R8: A change of the effective window length while enabled empties the window and restarts a full BLANK period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Detector enable |
| win_len_i | input | 6 | Requested window length in bits |
| lim_hi_i | input | 6 | Upper zero-count limit |
| lim_lo_i | input | 6 | Lower zero-count limit |
| sd_bit_i | input | 1 | Raw modulator bit |
| clr_i | input | 1 | Clear for both sticky error flags |
| err_hi_o | output | 1 | Upper-limit error (sticky, plus live violation) |
| err_lo_o | output | 1 | Lower-limit error (sticky, plus live violation) |
| trip_o | output | 1 | Trip-zone output |

## Verification
A running count that drifts by even one bit from the true window content shows at the error ports. The error appears or vanishes one cycle early or late as soon as the limits sit next to the real count. Tight limits under heavily biased bit streams therefore expose such a drift within about one window length. A blanking counter off by one cycle moves the first live error by one clock after enabling, and an all-zero stream against an upper limit of zero makes that visible. Stale window bits that survive a disable or a length change produce errors in what should be a fresh BLANK period, or a wrong count right after it.

// File: rtl/fd_pkg.sv
package fd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLANK = 2'd1,
        ST_WATCH = 2'd2
    } fd_state_e;
endpackage

// File: rtl/fd_ctrl.sv
module fd_ctrl
    import fd_pkg::*;
#(
    parameter int MAX_WIN    = 32,
    parameter int MIN_WIN    = 4,
    parameter int BLANK_CLKS = 32,
    localparam int CW = $clog2(MAX_WIN + 1),
    localparam int BW = $clog2(BLANK_CLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [CW-1:0] win_len_i,
    output logic [CW-1:0] len_c_o,
    output logic          flush_o,
    output logic          active_o
);
    fd_state_e     st_q, st_d;
    logic [CW-1:0] len_q;
    logic [BW-1:0] bl_cnt_q;
    logic          len_chg;

    always_comb begin
        if (win_len_i < CW'(MIN_WIN))      len_c_o = CW'(MIN_WIN);
        else if (win_len_i > CW'(MAX_WIN)) len_c_o = CW'(MAX_WIN);
        else                               len_c_o = win_len_i;
    end

    assign len_chg = (len_c_o != len_q);

    // next state
    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_BLANK;
                ST_BLANK: begin
                    if (len_chg)                           st_d = ST_BLANK;
                    else if (bl_cnt_q == BW'(BLANK_CLKS-1)) st_d = ST_WATCH;
                    else                                   st_d = ST_BLANK;
                end
                ST_WATCH: st_d = len_chg ? ST_BLANK : ST_WATCH;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            len_q    <= CW'(MAX_WIN);
            bl_cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            len_q <= len_c_o;
            if (flush_o)
                bl_cnt_q <= '0;
            else if (st_q == ST_BLANK)
                bl_cnt_q <= bl_cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        flush_o  = !en_i || (st_q == ST_IDLE) || len_chg;
        active_o = (st_q == ST_WATCH);
    end

    AST_WATCH_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WATCH && $past(st_q) != ST_WATCH) |-> $past(st_q) == ST_BLANK) else $error("watch entered without blank"); // R3
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> st_q == ST_IDLE) else $error("not idle after disable"); // R7
    AST_LEN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_q != ST_IDLE && len_chg) |=> st_q == ST_BLANK) else $error("length change did not restart"); // R8
endmodule

// File: rtl/fd_window.sv
module fd_window #(
    parameter int MAX_WIN = 32,
    localparam int CW = $clog2(MAX_WIN + 1),
    localparam int IW = $clog2(MAX_WIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          bit_i,
    input  logic [CW-1:0] len_c_i,
    output logic [CW-1:0] zcnt_o
);
    logic [MAX_WIN-1:0] sr_q;
    logic [IW-1:0]      out_idx;
    logic               in_z, out_z;

    assign out_idx = IW'(len_c_i - 1'b1);
    assign in_z    = ~bit_i;
    assign out_z   = ~sr_q[out_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '1;
            zcnt_o <= '0;
        end else if (flush_i) begin
            sr_q   <= '1;
            zcnt_o <= '0;
        end else begin
            sr_q   <= {sr_q[MAX_WIN-2:0], bit_i};
            zcnt_o <= zcnt_o + CW'(in_z) - CW'(out_z);
        end
    end

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> zcnt_o == '0) else $error("window not emptied"); // R7
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_i |=> (zcnt_o == $past(zcnt_o) || zcnt_o == $past(zcnt_o) + 1'b1 ||
                      zcnt_o + 1'b1 == $past(zcnt_o))) else $error("count jumped"); // R2
    AST_CNT_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_i |=> zcnt_o <= $past(len_c_i)) else $error("count above window"); // R2
endmodule

// File: rtl/fd_status.sv
module fd_status #(
    parameter int MAX_WIN = 32,
    localparam int CW = $clog2(MAX_WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic [CW-1:0] zcnt_i,
    input  logic [CW-1:0] lim_hi_i,
    input  logic [CW-1:0] lim_lo_i,
    input  logic          clr_i,
    output logic          err_hi_o,
    output logic          err_lo_o,
    output logic          trip_o
);
    logic over_now, under_now;
    logic st_hi_q, st_lo_q;

    always_comb begin
        over_now  = active_i && (zcnt_i > lim_hi_i);
        under_now = active_i && (zcnt_i < lim_lo_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_hi_q <= 1'b0;
            st_lo_q <= 1'b0;
        end else begin
            st_hi_q <= (st_hi_q && !clr_i) || over_now;
            st_lo_q <= (st_lo_q && !clr_i) || under_now;
        end
    end

    always_comb begin
        err_hi_o = st_hi_q || over_now;
        err_lo_o = st_lo_q || under_now;
        trip_o   = err_hi_o || err_lo_o;
    end

    AST_HI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_hi_o && !clr_i) |=> err_hi_o) else $error("hi flag lost"); // R6
    AST_LO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_lo_o && !clr_i) |=> err_lo_o) else $error("lo flag lost"); // R6
    AST_NEW_ERR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_o) |-> active_i) else $error("error raised while not comparing"); // R3
endmodule

// File: rtl/fd_fast_detect.sv
module fd_fast_detect #(
    parameter int MAX_WIN    = 32,
    parameter int MIN_WIN    = 4,
    parameter int BLANK_CLKS = 32,
    localparam int CW = $clog2(MAX_WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [CW-1:0] win_len_i,
    input  logic [CW-1:0] lim_hi_i,
    input  logic [CW-1:0] lim_lo_i,
    input  logic          sd_bit_i,
    input  logic          clr_i,
    output logic          err_hi_o,
    output logic          err_lo_o,
    output logic          trip_o
);
    logic [CW-1:0] len_c, zcnt;
    logic          flush, active;

    fd_ctrl #(.MAX_WIN(MAX_WIN), .MIN_WIN(MIN_WIN), .BLANK_CLKS(BLANK_CLKS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .win_len_i(win_len_i),
        .len_c_o(len_c), .flush_o(flush), .active_o(active)
    );

    fd_window #(.MAX_WIN(MAX_WIN)) u_win (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .bit_i(sd_bit_i),
        .len_c_i(len_c), .zcnt_o(zcnt)
    );

    fd_status #(.MAX_WIN(MAX_WIN)) u_stat (
        .clk(clk), .rst_n(rst_n), .active_i(active), .zcnt_i(zcnt),
        .lim_hi_i(lim_hi_i), .lim_lo_i(lim_lo_i), .clr_i(clr_i),
        .err_hi_o(err_hi_o), .err_lo_o(err_lo_o), .trip_o(trip_o)
    );

    AST_TRIP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !trip_o) |=> !trip_o) else $error("trip while disabled"); // R7
endmodule

// File: tb/fd_fast_detect_bench.sv
module fd_fast_detect_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [5:0] win = 6'd8;
    logic [5:0] lhi = 6'd32;
    logic [5:0] llo = 6'd0;
    logic       sdb = 1'b1;
    logic       clr = 1'b0;
    logic       ehi, elo, trip;

    int n_chk = 0;
    int n_bad = 0;
    string cur = "R6";
    bit done = 0;

    // reference model state
    int          m_st = 0;     // 0 idle, 1 blank, 2 watch
    int          m_bc = 0;
    logic [31:0] m_hist = '1;
    int          m_lenq = 32;
    bit          m_shi = 0, m_slo = 0;

    always #2.5 clk = ~clk;

    fd_fast_detect u_fd_fast_detect (
        .clk(clk), .rst_n(rst_n), .en_i(en), .win_len_i(win),
        .lim_hi_i(lhi), .lim_lo_i(llo), .sd_bit_i(sdb), .clr_i(clr),
        .err_hi_o(ehi), .err_lo_o(elo), .trip_o(trip)
    );

    function automatic int clampf(int v);
        if (v < 4) return 4;
        if (v > 32) return 32;
        return v;
    endfunction

    function automatic int mcount();
        logic [31:0] msk;
        msk = (m_lenq >= 32) ? 32'hffff_ffff : ((32'd1 << m_lenq) - 32'd1);
        return $countones(~m_hist & msk);
    endfunction

    task automatic chk(string what, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", cur, what, got, exp, $time);
        end
    endtask

    task automatic step();
        int  lc, c;
        bit  phi, plo, ehx, elx;
        lc  = clampf(int'(win));
        c   = mcount();
        phi = (m_st == 2) && (c > int'(lhi));
        plo = (m_st == 2) && (c < int'(llo));
        @(posedge clk);
        m_shi = (m_shi && !clr) || phi;
        m_slo = (m_slo && !clr) || plo;
        if (!en) begin
            m_st = 0; m_hist = '1;
        end else if (m_st == 0 || lc != m_lenq) begin
            m_st = 1; m_bc = 0; m_hist = '1;
        end else begin
            m_hist = {m_hist[30:0], sdb};
            if (m_st == 1) begin
                if (m_bc == 31) m_st = 2;
                else m_bc++;
            end
        end
        m_lenq = lc;
        @(negedge clk);
        c   = mcount();
        ehx = m_shi || ((m_st == 2) && (c > int'(lhi)));
        elx = m_slo || ((m_st == 2) && (c < int'(llo)));
        chk("err_hi", ehi, ehx);
        chk("err_lo", elo, elx);
        chk("trip", trip, ehx || elx);
    endtask

    task automatic run(int n, int pz, int pclr, int pdis, int plen);
        for (int i = 0; i < n; i++) begin
            sdb = (($urandom % 100) >= pz);
            clr = (($urandom % 100) < pclr);
            en  = !(($urandom % 100) < pdis);
            if (($urandom % 1000) < plen) win = 6'(4 + $urandom % 29);
            step();
        end
        clr = 1'b0; en = 1'b1;
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur = "R6";  // reset state
        chk("err_hi", ehi, 1'b0); chk("err_lo", elo, 1'b0); chk("trip", trip, 1'b0);

        // R3: all-zero stream, upper limit 0 -> error only after blanking
        cur = "R3"; en = 1'b1; win = 6'd16; lhi = 6'd0; llo = 6'd0; sdb = 1'b0;
        for (int i = 0; i < 40; i++) step();
        clr = 1'b1; lhi = 6'd32; step(); clr = 1'b0; step();

        // R1: clamping of low and high length codes
        cur = "R1"; lhi = 6'd3; llo = 6'd1;
        win = 6'd0;  run(60, 50, 0, 0, 0); clr = 1'b1; step();
        win = 6'd2;  run(60, 50, 0, 0, 0); clr = 1'b1; step();
        win = 6'd40; lhi = 6'd20; llo = 6'd12; run(60, 50, 0, 0, 0); clr = 1'b1; step();
        win = 6'd63; run(60, 50, 0, 0, 0); clr = 1'b1; step();

        // R2: random lengths, limits near the middle, frequent clears
        cur = "R2";
        for (int k = 0; k < 15; k++) begin
            win = 6'(4 + $urandom % 29);
            lhi = 6'(clampf(int'(win)) / 2 + 2);
            llo = 6'(clampf(int'(win)) / 2 - 2);
            run(120, 50, 20, 0, 0);
        end

        // R4: zero-heavy stream against the upper limit
        cur = "R4";
        for (int k = 0; k < 8; k++) begin
            lhi = 6'($urandom % 33); llo = 6'd0;
            run(150, 70, 5, 0, 2);
        end

        // R5: one-heavy stream against the lower limit
        cur = "R5";
        for (int k = 0; k < 8; k++) begin
            lhi = 6'd32; llo = 6'($urandom % 20);
            run(150, 25, 5, 0, 2);
        end

        // R6: clears with violations present
        cur = "R6"; win = 6'd8; lhi = 6'd5; llo = 6'd3;
        run(800, 50, 30, 0, 0);

        // R7: random disables
        cur = "R7"; win = 6'd12; lhi = 6'd8; llo = 6'd4;
        run(1000, 50, 10, 3, 0);

        // R8: frequent length changes
        cur = "R8"; lhi = 6'd10; llo = 6'd2;
        run(1200, 45, 10, 0, 30);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule